// File: doc/BRIEF.md
# Operand Forwarding Resolver

This block sits beside the decode stage of an in-order pipeline and settles, for every source operand of the instruction being decoded, where the operand comes from. There are three options. The operand can come from the register file. It can be taken from a later stage that is forwarding its result. Otherwise decode must stall. A per-register counter records how many issued instructions still owe a write to that register. Several writes to the same register may be in flight at once, and one instruction may write two registers.

Three stages offer results back to decode: execute, the memory stage (carrying execute results), and writeback (the value being written this cycle). Each stage reports, per result slot, whether it will write a given register and separately whether its data is ready now. Loads report ready only at writeback. The youngest claimant of a register always decides. If it cannot supply data, decode stalls, even when an older stage holds a ready value. The register file, the execution units and the issue logic are outside the block. The block only observes `issue_i` and reports `stall_o`.

Top module: `fwd_resolve`

## Requirements
- R1: A valid source whose register no stage claims and whose outstanding-write count is zero receives `rf_data_i` for that source, with select code 0 (register file) on `sel_o`.
- R2: A source claimed by a stage whose claiming slot is ready receives that slot's data in place of the register-file value.
- R3: When several slots claim the same register, the youngest wins: execute before memory before writeback, and within one stage slot 0 before slot 1. Select codes are 1 for execute, 2 for memory and 3 for writeback.
- R4: If the winning claimant of a valid source is not ready, `stall_o` is high, even when an older stage offers a ready value.
- R5: A valid source whose register has a nonzero outstanding count and that no stage claims raises `stall_o`.
- R6: An accepted issue (`issue_i` high while `stall_o` is low) adds one to the count of each valid destination. Each writeback slot write subtracts one. The register stays outstanding until every write has retired.
- R7: An issue presented while `stall_o` is high leaves the counts unchanged.
- R8: A register written back in the current cycle is forwarded from writeback in that cycle (select 3). After that clock edge, if no other writes are outstanding, the register reads from the register file.
- R9: Sources without their valid flag never cause a stall. Register 0 is handled like any other register.
- R10: `stall_o` is the OR of the per-source stall conditions. Sources that do not stall still receive their resolved values.
- R11: The asynchronous reset clears every outstanding count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_vld_i | input | NSRC | Source operand in use, one bit per source |
| src_idx_i | input | NSRC*IDX_W | Register index per source |
| rf_data_i | input | NSRC*XLEN | Register-file read data per source |
| issue_i | input | 1 | Decode instruction leaves this cycle unless stalled |
| iss_dst_vld_i | input | NDST | Destination slot in use for the issuing instruction |
| iss_dst_idx_i | input | NDST*IDX_W | Destination register per slot |
| exe_wr_en_i | input | NDST | Execute slot will write a register |
| exe_wr_idx_i | input | NDST*IDX_W | Execute slot destination |
| exe_rdy_i | input | NDST | Execute slot data ready now |
| exe_data_i | input | NDST*XLEN | Execute slot data |
| mem_wr_en_i | input | NDST | Memory-stage slot will write a register |
| mem_wr_idx_i | input | NDST*IDX_W | Memory-stage slot destination |
| mem_rdy_i | input | NDST | Memory-stage slot data ready now |
| mem_data_i | input | NDST*XLEN | Memory-stage slot data |
| wb_wr_en_i | input | NDST | Writeback slot writes the register file this cycle |
| wb_wr_idx_i | input | NDST*IDX_W | Writeback slot destination |
| wb_data_i | input | NDST*XLEN | Writeback slot data |
| opnd_o | output | NSRC*XLEN | Resolved operand per source |
| sel_o | output | NSRC*2 | Select code per source (0 file, 1 execute, 2 memory, 3 writeback) |
| stall_o | output | 1 | Decode must hold |

## Verification
The hardest case to reach from the ports is a register that is outstanding while no stage claims it. The case gets harder when two writes to that register are pending and only one has retired. The stimulus issues the same destination twice while no source is valid. It then retires one write through writeback, where the value must be forwarded in that very cycle. The source must then stall on the next cycle and read the register file only after the second retirement. A second hard case is an issue that arrives during a stall. The bench creates that stall first, presents the issue, and then shows that the new destination never became outstanding.

// File: rtl/fwd_pkg.sv
`timescale 1ns/1ps
package fwd_pkg;
  typedef enum logic [1:0] {
    SEL_RF  = 2'd0,
    SEL_EXE = 2'd1,
    SEL_MEM = 2'd2,
    SEL_WB  = 2'd3
  } src_sel_e;
endpackage

// File: rtl/fwd_scoreboard.sv
`timescale 1ns/1ps
module fwd_scoreboard #(
  parameter int NREG  = 32,
  parameter int NDST  = 2,
  parameter int CNT_W = 3,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    issue_i,
  input  logic [NDST-1:0]         dst_vld_i,
  input  logic [NDST*IDX_W-1:0]   dst_idx_i,
  input  logic [NDST-1:0]         ret_vld_i,
  input  logic [NDST*IDX_W-1:0]   ret_idx_i,
  output logic [NREG-1:0]         stale_o
);
  localparam logic [CNT_W:0] CMAX = {1'b0, {CNT_W{1'b1}}};

  for (genvar r = 0; r < NREG; r++) begin : g_ent
    logic [CNT_W-1:0] cnt_q, cnt_d, inc, dec;
    logic [CNT_W:0]   sum;

    always_comb begin
      inc = '0;
      dec = '0;
      for (int d = 0; d < NDST; d++) begin
        if (issue_i && dst_vld_i[d] && dst_idx_i[d*IDX_W +: IDX_W] == IDX_W'(r))
          inc = inc + CNT_W'(1);
        if (ret_vld_i[d] && ret_idx_i[d*IDX_W +: IDX_W] == IDX_W'(r))
          dec = dec + CNT_W'(1);
      end
      sum = {1'b0, cnt_q} + {1'b0, inc};
      // clamp at both ends; retire without owner leaves zero
      if (sum <= {1'b0, dec})              cnt_d = '0;
      else if (sum - {1'b0, dec} > CMAX)   cnt_d = CMAX[CNT_W-1:0];
      else                                 cnt_d = CNT_W'(sum - {1'b0, dec});
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q <= '0;
      else         cnt_q <= cnt_d;
    end

    assign stale_o[r] = |cnt_q;
  end
endmodule

// File: rtl/fwd_stage_match.sv
`timescale 1ns/1ps
module fwd_stage_match #(
  parameter int XLEN  = 32,
  parameter int NDST  = 2,
  parameter int IDX_W = 5
) (
  input  logic [IDX_W-1:0]       idx_i,
  input  logic [NDST-1:0]        wr_en_i,
  input  logic [NDST*IDX_W-1:0]  wr_idx_i,
  input  logic [NDST-1:0]        rdy_i,
  input  logic [NDST*XLEN-1:0]   data_i,
  output logic                   hit_o,
  output logic                   rdy_o,
  output logic [XLEN-1:0]        data_o
);
  // lowest slot claiming the register wins
  always_comb begin
    hit_o  = 1'b0;
    rdy_o  = 1'b0;
    data_o = '0;
    for (int d = NDST-1; d >= 0; d--) begin
      if (wr_en_i[d] && wr_idx_i[d*IDX_W +: IDX_W] == idx_i) begin
        hit_o  = 1'b1;
        rdy_o  = rdy_i[d];
        data_o = data_i[d*XLEN +: XLEN];
      end
    end
  end
endmodule

// File: rtl/fwd_src_resolve.sv
`timescale 1ns/1ps
module fwd_src_resolve import fwd_pkg::*; #(
  parameter int XLEN = 32,
  localparam int NST = 3
) (
  input  logic                  vld_i,
  input  logic                  stale_i,
  input  logic [NST-1:0]        hit_i,
  input  logic [NST-1:0]        rdy_i,
  input  logic [NST*XLEN-1:0]   data_i,
  input  logic [XLEN-1:0]       rf_i,
  output logic [XLEN-1:0]       data_o,
  output src_sel_e              sel_o,
  output logic                  stall_o
);
  // stage 0 is youngest; first claimant decides
  always_comb begin
    data_o  = rf_i;
    sel_o   = SEL_RF;
    stall_o = vld_i && stale_i;
    for (int t = NST-1; t >= 0; t--) begin
      if (hit_i[t]) begin
        data_o  = data_i[t*XLEN +: XLEN];
        sel_o   = src_sel_e'(2'(t + 1));
        stall_o = vld_i && !rdy_i[t];
      end
    end
  end
endmodule

// File: rtl/fwd_resolve.sv
`timescale 1ns/1ps
module fwd_resolve import fwd_pkg::*; #(
  parameter int XLEN  = 32,
  parameter int NREG  = 32,
  parameter int NSRC  = 3,
  parameter int NDST  = 2,
  parameter int CNT_W = 3,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NSRC-1:0]        src_vld_i,
  input  logic [NSRC*IDX_W-1:0]  src_idx_i,
  input  logic [NSRC*XLEN-1:0]   rf_data_i,
  input  logic                   issue_i,
  input  logic [NDST-1:0]        iss_dst_vld_i,
  input  logic [NDST*IDX_W-1:0]  iss_dst_idx_i,
  input  logic [NDST-1:0]        exe_wr_en_i,
  input  logic [NDST*IDX_W-1:0]  exe_wr_idx_i,
  input  logic [NDST-1:0]        exe_rdy_i,
  input  logic [NDST*XLEN-1:0]   exe_data_i,
  input  logic [NDST-1:0]        mem_wr_en_i,
  input  logic [NDST*IDX_W-1:0]  mem_wr_idx_i,
  input  logic [NDST-1:0]        mem_rdy_i,
  input  logic [NDST*XLEN-1:0]   mem_data_i,
  input  logic [NDST-1:0]        wb_wr_en_i,
  input  logic [NDST*IDX_W-1:0]  wb_wr_idx_i,
  input  logic [NDST*XLEN-1:0]   wb_data_i,
  output logic [NSRC*XLEN-1:0]   opnd_o,
  output logic [NSRC*2-1:0]      sel_o,
  output logic                   stall_o
);
  localparam int NST = 3;

  logic [NDST-1:0]       st_en   [NST];
  logic [NDST*IDX_W-1:0] st_idx  [NST];
  logic [NDST-1:0]       st_rdy  [NST];
  logic [NDST*XLEN-1:0]  st_data [NST];
  logic [NREG-1:0]       stale;
  logic [NSRC-1:0]       src_stall;

  // youngest stage first
  assign st_en[0]   = exe_wr_en_i;
  assign st_idx[0]  = exe_wr_idx_i;
  assign st_rdy[0]  = exe_rdy_i;
  assign st_data[0] = exe_data_i;
  assign st_en[1]   = mem_wr_en_i;
  assign st_idx[1]  = mem_wr_idx_i;
  assign st_rdy[1]  = mem_rdy_i;
  assign st_data[1] = mem_data_i;
  assign st_en[2]   = wb_wr_en_i;
  assign st_idx[2]  = wb_wr_idx_i;
  assign st_rdy[2]  = '1;
  assign st_data[2] = wb_data_i;

  fwd_scoreboard #(
    .NREG  (NREG),
    .NDST  (NDST),
    .CNT_W (CNT_W)
  ) u_sb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .issue_i   (issue_i && !stall_o),
    .dst_vld_i (iss_dst_vld_i),
    .dst_idx_i (iss_dst_idx_i),
    .ret_vld_i (wb_wr_en_i),
    .ret_idx_i (wb_wr_idx_i),
    .stale_o   (stale)
  );

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    logic [IDX_W-1:0]    idx;
    logic [NST-1:0]      hit, rdy;
    logic [NST*XLEN-1:0] dat;
    src_sel_e            sel;

    assign idx = src_idx_i[s*IDX_W +: IDX_W];

    for (genvar t = 0; t < NST; t++) begin : g_st
      fwd_stage_match #(
        .XLEN  (XLEN),
        .NDST  (NDST),
        .IDX_W (IDX_W)
      ) u_match (
        .idx_i    (idx),
        .wr_en_i  (st_en[t]),
        .wr_idx_i (st_idx[t]),
        .rdy_i    (st_rdy[t]),
        .data_i   (st_data[t]),
        .hit_o    (hit[t]),
        .rdy_o    (rdy[t]),
        .data_o   (dat[t*XLEN +: XLEN])
      );
    end

    fwd_src_resolve #(
      .XLEN (XLEN)
    ) u_res (
      .vld_i   (src_vld_i[s]),
      .stale_i (stale[idx]),
      .hit_i   (hit),
      .rdy_i   (rdy),
      .data_i  (dat),
      .rf_i    (rf_data_i[s*XLEN +: XLEN]),
      .data_o  (opnd_o[s*XLEN +: XLEN]),
      .sel_o   (sel),
      .stall_o (src_stall[s])
    );

    assign sel_o[s*2 +: 2] = sel;
  end

  assign stall_o = |src_stall;
endmodule

// File: rtl/fwd_resolve_chk.sv
`timescale 1ns/1ps
module fwd_resolve_chk import fwd_pkg::*; #(
  parameter int XLEN  = 32,
  parameter int NREG  = 32,
  parameter int NSRC  = 3,
  parameter int NDST  = 2,
  parameter int CNT_W = 3,
  localparam int IDX_W = $clog2(NREG)
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [NSRC-1:0]        src_vld_i,
  input logic [NSRC*IDX_W-1:0]  src_idx_i,
  input logic [NSRC*XLEN-1:0]   rf_data_i,
  input logic                   issue_i,
  input logic [NDST-1:0]        iss_dst_vld_i,
  input logic [NDST*IDX_W-1:0]  iss_dst_idx_i,
  input logic [NDST-1:0]        exe_wr_en_i,
  input logic [NDST*IDX_W-1:0]  exe_wr_idx_i,
  input logic [NDST-1:0]        exe_rdy_i,
  input logic [NDST*XLEN-1:0]   exe_data_i,
  input logic [NDST-1:0]        mem_wr_en_i,
  input logic [NDST*IDX_W-1:0]  mem_wr_idx_i,
  input logic [NDST-1:0]        mem_rdy_i,
  input logic [NDST*XLEN-1:0]   mem_data_i,
  input logic [NDST-1:0]        wb_wr_en_i,
  input logic [NDST*IDX_W-1:0]  wb_wr_idx_i,
  input logic [NDST*XLEN-1:0]   wb_data_i,
  input logic [NSRC*XLEN-1:0]   opnd_o,
  input logic [NSRC*2-1:0]      sel_o,
  input logic                   stall_o
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  a_r9_idle_no_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_vld_i == '0) |-> !stall_o);

  for (genvar s = 0; s < NSRC; s++) begin : g_chk
    logic [IDX_W-1:0] want;
    logic [XLEN-1:0]  opnd, rf, ex_d, mm_d, wb_d;
    logic             vld, ex_hit, ex_rdy, mm_hit, mm_rdy, wb_hit;
    logic [1:0]       sel;

    always_comb begin
      want = src_idx_i[s*IDX_W +: IDX_W];
      opnd = opnd_o[s*XLEN +: XLEN];
      rf   = rf_data_i[s*XLEN +: XLEN];
      vld  = src_vld_i[s];
      sel  = sel_o[s*2 +: 2];
      ex_hit = 1'b0; ex_rdy = 1'b0; ex_d = '0;
      mm_hit = 1'b0; mm_rdy = 1'b0; mm_d = '0;
      wb_hit = 1'b0; wb_d = '0;
      for (int d = NDST-1; d >= 0; d--) begin
        if (exe_wr_en_i[d] && exe_wr_idx_i[d*IDX_W +: IDX_W] == want) begin
          ex_hit = 1'b1; ex_rdy = exe_rdy_i[d]; ex_d = exe_data_i[d*XLEN +: XLEN];
        end
        if (mem_wr_en_i[d] && mem_wr_idx_i[d*IDX_W +: IDX_W] == want) begin
          mm_hit = 1'b1; mm_rdy = mem_rdy_i[d]; mm_d = mem_data_i[d*XLEN +: XLEN];
        end
        if (wb_wr_en_i[d] && wb_wr_idx_i[d*IDX_W +: IDX_W] == want) begin
          wb_hit = 1'b1; wb_d = wb_data_i[d*XLEN +: XLEN];
        end
      end
    end

    a_r1_rf_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vld && sel == SEL_RF && !stall_o |-> opnd == rf);

    a_r3_exe_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vld && ex_hit && ex_rdy |-> sel == SEL_EXE && opnd == ex_d);

    a_r4_exe_unready_stalls: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vld && ex_hit && !ex_rdy |-> stall_o);

    a_r3_mem_over_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vld && !ex_hit && mm_hit && mm_rdy |-> sel == SEL_MEM && opnd == mm_d);

    a_r8_wb_shortcut: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vld && !ex_hit && !mm_hit && wb_hit |-> sel == SEL_WB && opnd == wb_d);

    a_r6_issue_marks: assert property (@(posedge clk_i) disable iff (!rst_ni)
      seen_q && vld && !ex_hit && !mm_hit && !wb_hit &&
      $past(issue_i && !stall_o && iss_dst_vld_i[0] && !(|wb_wr_en_i)) &&
      $past(iss_dst_idx_i[IDX_W-1:0]) == want |-> stall_o);
  end
endmodule

bind fwd_resolve fwd_resolve_chk #(
  .XLEN  (XLEN),
  .NREG  (NREG),
  .NSRC  (NSRC),
  .NDST  (NDST),
  .CNT_W (CNT_W)
) u_chk (.*);

// File: tb/fwd_resolve_test.sv
`timescale 1ns/1ps
module fwd_resolve_test;
  localparam int XLEN = 32, NSRC = 3, NDST = 2, IDX_W = 5, NVEC = 17;

  logic                  clk_i = 1'b0;
  logic                  rst_ni = 1'b0;
  logic [NSRC-1:0]       src_vld_i;
  logic [NSRC*IDX_W-1:0] src_idx_i;
  logic [NSRC*XLEN-1:0]  rf_data_i;
  logic                  issue_i;
  logic [NDST-1:0]       iss_dst_vld_i;
  logic [NDST*IDX_W-1:0] iss_dst_idx_i;
  logic [NDST-1:0]       exe_wr_en_i, exe_rdy_i, mem_wr_en_i, mem_rdy_i, wb_wr_en_i;
  logic [NDST*IDX_W-1:0] exe_wr_idx_i, mem_wr_idx_i, wb_wr_idx_i;
  logic [NDST*XLEN-1:0]  exe_data_i, mem_data_i, wb_data_i;
  logic [NSRC*XLEN-1:0]  opnd_o;
  logic [NSRC*2-1:0]     sel_o;
  logic                  stall_o;

  int  errors = 0, checks = 0;
  bit  done = 0;

  always #2 clk_i = ~clk_i;

  fwd_resolve uut (.*);

  // claim code: -1 none, 0..31 ready claim of that reg, 32..63 unready claim of (c-32)
  function automatic logic [6:0] cl(input int c);
    if (c < 0) return 7'd0;
    return {1'b1, 5'(c % 32), (c < 32)};
  endfunction
  function automatic logic [5:0] wl(input int c);
    if (c < 0) return 6'd0;
    return {1'b1, 5'(c)};
  endfunction
  // slot: 0 rf, 1 exe0, 2 exe1, 3 mem0, 4 mem1, 5 wb0, 6 wb1
  function automatic logic [48:0] v(input int src, e0, e1, m0, m1, w0, w1, slot, stl);
    logic [48:0] r;
    r[48:44] = 5'(src);
    r[43:37] = cl(e0); r[36:30] = cl(e1);
    r[29:23] = cl(m0); r[22:16] = cl(m1);
    r[15:10] = wl(w0); r[9:4]   = wl(w1);
    r[3:1]   = 3'(slot); r[0]   = 1'(stl);
    return r;
  endfunction

  localparam logic [48:0] VEC [NVEC] = '{
    v(5, -1, -1, -1, -1, -1, -1, 0, 0),  // R1 nothing claims
    v(5,  5, -1, -1, -1, -1, -1, 1, 0),  // R2 exe0
    v(5, -1,  5, -1, -1, -1, -1, 2, 0),  // R2 exe1
    v(5, -1, -1,  5, -1, -1, -1, 3, 0),  // R2 mem0
    v(5, -1, -1, -1,  5, -1, -1, 4, 0),  // R2 mem1
    v(5, -1, -1, -1, -1,  5, -1, 5, 0),  // R8 wb0
    v(5, -1, -1, -1, -1, -1,  5, 6, 0),  // R8 wb1
    v(5, 37, -1,  5, -1, -1, -1, 0, 1),  // R4 exe unready hides mem
    v(5, 38, -1, -1,  5, -1, -1, 4, 0),  // R3 unrelated unready exe
    v(5,  5, -1,  5, -1,  5, -1, 1, 0),  // R3 youngest of three
    v(5, -1, -1, 37, -1,  5, -1, 0, 1),  // R4 load in mem, wb older
    v(5, -1, -1,  5, -1,  5,  5, 3, 0),  // R3 mem over wb
    v(5,  5,  5, -1, -1, -1, -1, 1, 0),  // R3 slot0 over slot1
    v(5, -1, 37,  5, -1, -1, -1, 0, 1),  // R4 exe1 unready
    v(0,  0, -1, -1, -1, -1, -1, 1, 0),  // R9 register 0 ordinary
    v(5,  7, -1,  8, -1,  9,  9, 0, 0),  // R1 other regs only
    v(5,  5, 37, -1, -1, -1, -1, 1, 0)   // R3 ready slot0 beats slot1
  };

  function automatic logic [31:0] slot_data(input int slot);
    case (slot)
      1: return 32'h1111_0000;  2: return 32'h1111_0001;
      3: return 32'h2222_0000;  4: return 32'h2222_0001;
      5: return 32'h3333_0000;  6: return 32'h3333_0001;
      default: return 32'h4444_0000;
    endcase
  endfunction
  function automatic logic [1:0] slot_sel(input int slot);
    case (slot)
      1, 2: return 2'd1;
      3, 4: return 2'd2;
      5, 6: return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    src_vld_i = '0; src_idx_i = '0;
    rf_data_i = {32'h4444_0002, 32'h4444_0001, 32'h4444_0000};
    issue_i = 1'b0; iss_dst_vld_i = '0; iss_dst_idx_i = '0;
    exe_wr_en_i = '0; exe_wr_idx_i = '0; exe_rdy_i = '0;
    mem_wr_en_i = '0; mem_wr_idx_i = '0; mem_rdy_i = '0;
    wb_wr_en_i = '0; wb_wr_idx_i = '0;
    exe_data_i = {32'h1111_0001, 32'h1111_0000};
    mem_data_i = {32'h2222_0001, 32'h2222_0000};
    wb_data_i  = {32'h3333_0001, 32'h3333_0000};
  endtask

  task automatic cyc(); @(negedge clk_i); idle(); endtask

  task automatic issue_one(input int r);
    cyc(); issue_i = 1'b1; iss_dst_vld_i = 2'b01; iss_dst_idx_i[4:0] = 5'(r);
  endtask

  task automatic retire_one(input int r);
    cyc(); wb_wr_en_i = 2'b01; wb_wr_idx_i[4:0] = 5'(r);
  endtask

  task automatic src0(input int r);
    src_vld_i[0] = 1'b1; src_idx_i[4:0] = 5'(r);
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;

    // reset state
    cyc(); src0(9); #1;
    chk("R11", "stall after reset", 32'(stall_o), 32'd0);
    chk("R11", "sel after reset", 32'(sel_o[1:0]), 32'd0);
    chk("R1", "rf operand", opnd_o[31:0], 32'h4444_0000);

    // table walk, source 0 only
    for (int i = 0; i < NVEC; i++) begin
      logic [48:0] e;
      int slot;
      e = VEC[i];
      slot = int'(e[3:1]);
      cyc();
      src_vld_i[0] = 1'b1; src_idx_i[4:0] = e[48:44];
      exe_wr_en_i[0] = e[43]; exe_wr_idx_i[4:0] = e[42:38]; exe_rdy_i[0] = e[37];
      exe_wr_en_i[1] = e[36]; exe_wr_idx_i[9:5] = e[35:31]; exe_rdy_i[1] = e[30];
      mem_wr_en_i[0] = e[29]; mem_wr_idx_i[4:0] = e[28:24]; mem_rdy_i[0] = e[23];
      mem_wr_en_i[1] = e[22]; mem_wr_idx_i[9:5] = e[21:17]; mem_rdy_i[1] = e[16];
      wb_wr_en_i[0]  = e[15]; wb_wr_idx_i[4:0]  = e[14:10];
      wb_wr_en_i[1]  = e[9];  wb_wr_idx_i[9:5]  = e[8:4];
      #1;
      if (e[0]) begin
        chk("R4", $sformatf("vec%0d stall", i), 32'(stall_o), 32'd1);
      end else begin
        chk(slot == 0 ? "R1" : "R3", $sformatf("vec%0d stall", i), 32'(stall_o), 32'd0);
        chk("R3", $sformatf("vec%0d sel", i), 32'(sel_o[1:0]), 32'(slot_sel(slot)));
        chk(slot == 0 ? "R1" : "R2", $sformatf("vec%0d data", i), opnd_o[31:0], slot_data(slot));
      end
    end

    // R5 outstanding and unclaimed
    issue_one(9);
    cyc(); src0(9); #1;
    chk("R5", "stale unclaimed stall", 32'(stall_o), 32'd1);

    // R6 second outstanding write, partial retirement, R8 shortcut
    issue_one(9);
    cyc(); src0(9); wb_wr_en_i = 2'b01; wb_wr_idx_i[4:0] = 5'd9; #1;
    chk("R8", "wb shortcut stall", 32'(stall_o), 32'd0);
    chk("R8", "wb shortcut sel", 32'(sel_o[1:0]), 32'd3);
    chk("R8", "wb shortcut data", opnd_o[31:0], 32'h3333_0000);
    cyc(); src0(9); #1;
    chk("R6", "one write still pending", 32'(stall_o), 32'd1);
    retire_one(9);
    cyc(); src0(9); #1;
    chk("R6", "all retired stall", 32'(stall_o), 32'd0);
    chk("R6", "all retired sel", 32'(sel_o[1:0]), 32'd0);

    // R7 issue during stall ignored
    issue_one(13);
    cyc(); src0(13); issue_i = 1'b1; iss_dst_vld_i = 2'b01; iss_dst_idx_i[4:0] = 5'd14; #1;
    chk("R7", "stall precondition", 32'(stall_o), 32'd1);
    retire_one(13);
    cyc(); src0(14); #1;
    chk("R7", "r14 never marked", 32'(stall_o), 32'd0);
    chk("R7", "r14 from file", opnd_o[31:0], 32'h4444_0000);

    // R6 two destinations in one issue
    cyc(); issue_i = 1'b1; iss_dst_vld_i = 2'b11;
    iss_dst_idx_i = {5'd21, 5'd20};
    cyc(); src_vld_i[1] = 1'b1; src_idx_i[9:5] = 5'd21; #1;
    chk("R6", "second dest marked", 32'(stall_o), 32'd1);
    cyc(); src_vld_i[2] = 1'b1; src_idx_i[14:10] = 5'd20; #1;
    chk("R6", "first dest marked", 32'(stall_o), 32'd1);
    cyc(); wb_wr_en_i = 2'b11; wb_wr_idx_i = {5'd21, 5'd20};
    cyc(); src_vld_i = 3'b011; src_idx_i[4:0] = 5'd20; src_idx_i[9:5] = 5'd21; #1;
    chk("R6", "dual retire clean", 32'(stall_o), 32'd0);

    // R9 invalid source never stalls
    issue_one(22);
    cyc(); src_idx_i[4:0] = 5'd22; exe_wr_en_i[0] = 1'b1; exe_wr_idx_i[4:0] = 5'd22; #1;
    chk("R9", "invalid source", 32'(stall_o), 32'd0);
    retire_one(22);

    // R10 multi-source
    cyc();
    src_vld_i = 3'b111;
    src_idx_i = {5'd7, 5'd6, 5'd5};
    exe_wr_en_i[0] = 1'b1; exe_wr_idx_i[4:0] = 5'd5; exe_rdy_i[0] = 1'b1;
    mem_wr_en_i[0] = 1'b1; mem_wr_idx_i[4:0] = 5'd6; mem_rdy_i[0] = 1'b0;
    #1;
    chk("R10", "one source stalls all", 32'(stall_o), 32'd1);
    chk("R10", "src0 still resolved", opnd_o[31:0], 32'h1111_0000);
    chk("R10", "src2 from file", opnd_o[95:64], 32'h4444_0002);
    mem_rdy_i[0] = 1'b1; #1;
    chk("R10", "all ready", 32'(stall_o), 32'd0);
    chk("R2", "src1 from mem", opnd_o[63:32], 32'h2222_0000);
    chk("R2", "src1 sel mem", 32'(sel_o[3:2]), 32'd2);

    // R11 reset clears counts
    issue_one(30);
    cyc(); src0(30); #1;
    chk("R11", "r30 outstanding", 32'(stall_o), 32'd1);
    rst_ni = 1'b0;
    cyc(); rst_ni = 1'b1;
    cyc(); src0(30); #1;
    chk("R11", "reset cleared count", 32'(stall_o), 32'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule